// File: doc/BRIEF.md
# Bidirectional Crossbar Pulse-Width Drive Sequencer

This block is the digital controller placed next to an analog resistive crossbar. A processor loads an input vector into a small register file, chooses a direction and a coding mode, and issues a start. The sequencer turns every element into an enable pulse of fixed amplitude whose length in clocks carries the value. In forward direction these pulses go to the row drivers. In transposed direction they go to the column drivers. Lines on the opposite side stay in sense mode, where their integrating converters collect charge.

The integrate window opens on the clock in which all pulses begin together. It stays open for a fixed tail after the longest pulse ends. Once it closes, a one-cycle conversion strobe goes to the converters on the sensed side. When the converters report completion, their results are latched into readable result registers and a done flag rises. The highest-numbered line on the driven side is a bias line that is always driven as a constant one.

Two coding modes exist. In value mode the pulse length is the stored number. In binary mode bit 0 of each element selects either a pulse of a programmable unit length or no pulse at all.

Top module: `xbar_pwm_seq`

## Requirements
- R1: After synchronous reset the block is idle: no pulse on any line, integrate window low, both conversion strobes low, done and overrun low, forward direction latched (rows driven, columns sensing), and every result register reads 0.
- R2: In value mode (bin_mode=0), each driven data line k pulses for exactly vec[k] clocks. All pulses begin in the cycle after the start is accepted. A value of 0 gives no pulse.
- R3: In binary mode (bin_mode=1), a driven data line whose stored bit 0 is 1 pulses for unit_len clocks. A line whose bit 0 is 0 stays low, whatever its upper bits hold.
- R4: The bias line is the last line of the driven side (row NR-1 when forward, column NC-1 when transposed). It always pulses: for 2^W-1 clocks in value mode and for unit_len clocks in binary mode.
- R5: dir_sel=0 (forward) drives rows from data elements 0..NR-2 and puts all columns in sense mode. dir_sel=1 (transpose) drives columns from elements 0..NC-2 and puts all rows in sense mode. No line in sense mode ever pulses.
- R6: The integrate window is high from the first drive cycle through TAIL cycles after the longest pulse ends. It lasts at least one drive cycle even when no line pulses.
- R7: A conversion strobe of exactly one cycle is issued to the sensed side only (conv_go_col when forward, conv_go_row when transposed), in the cycle right after the window closes.
- R8: When conv_done arrives after the strobe, result j latches the sensed side's converter word j (zero beyond that side's line count). Then done rises, busy falls, and the results are readable through rd_idx. done stays high until the next accepted start.
- R9: A start that arrives while busy is ignored and sets overrun, which then stays set until reset.
- R10: Changes to dir_sel, bin_mode or unit_len while busy have no effect on the operation in flight. The direction is latched at the accepted start.
- R11: A write with wr_en stores wr_data into element wr_idx (0..NMAX-2). The stored element is used by every later start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Input vector element write |
| wr_idx | input | IW | Element index for writes |
| wr_data | input | W | Element value |
| start | input | 1 | Request an operation |
| dir_sel | input | 1 | 0 forward, 1 transpose |
| bin_mode | input | 1 | 1 binary coding, 0 value coding |
| unit_len | input | W | Pulse length for binary ones and the binary bias |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Results valid |
| overrun | output | 1 | Sticky: start seen while busy |
| rd_idx | input | IW | Result register select |
| rd_data | output | RW | Selected result |
| row_pulse | output | NR | Row drive enables |
| col_pulse | output | NC | Column drive enables |
| row_sense | output | 1 | Rows held in sense mode |
| col_sense | output | 1 | Columns held in sense mode |
| integ | output | 1 | Integrate window |
| conv_go_row | output | 1 | Conversion start, row converters |
| conv_go_col | output | 1 | Conversion start, column converters |
| conv_done | input | 1 | Converters finished |
| row_adc | input | NR*RW | Row converter words, row r at bits r*RW |
| col_adc | input | NC*RW | Column converter words, column c at bits c*RW |

## Verification
The bench builds the block with six rows and four columns, so the two directions have different line counts. This exposes any mix-up between the driven side and the sensed side, including result slots beyond the shorter side, which must read zero. A 4-bit pulse width keeps the full-scale bias pulse at 15 clocks. That allows many operations per run, while still covering the case where a data value equals full scale. A two-cycle tail places the strobe well clear of the last pulse edge. A converter stub adds up the pulses it sees through a fixed conductance pattern, so a wrong pulse length also shows up in the latched results.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRIVE = 3'd1,
        ST_TAIL  = 3'd2,
        ST_CONV  = 3'd3,
        ST_WAIT  = 3'd4
    } seq_state_e;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_TRN = 1'b1
    } xdir_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic overrun;
    } seq_flags_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xbar_lane.sv
module xbar_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         active,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q <= W'(1));

    // A running lane only counts down until it expires (R2)
    assert_lane_countdown_R2: assert property (@(posedge clk) disable iff (rst)
        (active && !load) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
    import xbar_pkg::*;
#(
    parameter int TAIL = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       all_last,
    input  logic       conv_done,
    output logic       accept,
    output logic       integ,
    output logic       conv_go,
    output logic       latch,
    output seq_flags_t flags
);
    localparam int TW = max_of($clog2(TAIL + 1), 1);

    seq_state_e   state_q;
    logic [TW-1:0] tcnt_q;
    logic          done_q;
    logic          over_q;

    assign accept  = start && (state_q == ST_IDLE);
    assign integ   = (state_q == ST_DRIVE) || (state_q == ST_TAIL);
    assign conv_go = (state_q == ST_CONV);
    assign latch   = (state_q == ST_WAIT) && conv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (accept) state_q <= ST_DRIVE;
                ST_DRIVE: if (all_last) begin
                    state_q <= ST_TAIL;
                    tcnt_q  <= TW'(TAIL - 1);
                end
                ST_TAIL: begin
                    if (tcnt_q == '0) state_q <= ST_CONV;
                    else tcnt_q <= tcnt_q - TW'(1);
                end
                ST_CONV:  state_q <= ST_WAIT;
                ST_WAIT:  if (conv_done) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            over_q <= 1'b0;
        end else begin
            if (accept) done_q <= 1'b0;
            else if (latch) done_q <= 1'b1;
            if (start && state_q != ST_IDLE) over_q <= 1'b1;
        end
    end

    assign flags.busy    = (state_q != ST_IDLE);
    assign flags.done    = done_q;
    assign flags.overrun = over_q;

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        conv_go |=> !conv_go);
    assert_strobe_after_window_R7: assert property (@(posedge clk) disable iff (rst)
        conv_go |-> (!integ && $past(integ)));
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        flags.overrun |=> flags.overrun);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        flags.done |-> !flags.busy);
    assert_window_opens_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(integ) |-> $past(accept));
endmodule

// File: rtl/xbar_results.sv
module xbar_results
    import xbar_pkg::*;
#(
    parameter int NR   = 6,
    parameter int NC   = 4,
    parameter int RW   = 16,
    parameter int NMAX = 6,
    parameter int IW   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch,
    input  xdir_e            dir,
    input  logic [NR*RW-1:0] row_adc,
    input  logic [NC*RW-1:0] col_adc,
    input  logic [IW-1:0]    rd_idx,
    output logic [RW-1:0]    rd_data
);
    logic [RW-1:0] res_q [NMAX];

    for (genvar j = 0; j < NMAX; j++) begin : g_res
        logic [RW-1:0] from_row;
        logic [RW-1:0] from_col;
        if (j < NR) begin : g_r
            assign from_row = row_adc[j*RW +: RW];
        end else begin : g_rz
            assign from_row = '0;
        end
        if (j < NC) begin : g_c
            assign from_col = col_adc[j*RW +: RW];
        end else begin : g_cz
            assign from_col = '0;
        end
        always_ff @(posedge clk) begin
            if (rst)
                res_q[j] <= '0;
            else if (latch)
                res_q[j] <= (dir == DIR_TRN) ? from_row : from_col;
        end
    end

    assign rd_data = (int'(rd_idx) < NMAX) ? res_q[rd_idx] : '0;

    assert_results_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(latch) |-> $stable(res_q[0]));
endmodule

// File: rtl/xbar_pwm_seq.sv
module xbar_pwm_seq
    import xbar_pkg::*;
#(
    parameter int NR   = 6,
    parameter int NC   = 4,
    parameter int W    = 8,
    parameter int RW   = 16,
    parameter int TAIL = 3,
    localparam int NMAX = max_of(NR, NC),
    localparam int IW   = max_of($clog2(NMAX), 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic             start,
    input  logic             dir_sel,
    input  logic             bin_mode,
    input  logic [W-1:0]     unit_len,
    output logic             busy,
    output logic             done,
    output logic             overrun,
    input  logic [IW-1:0]    rd_idx,
    output logic [RW-1:0]    rd_data,
    output logic [NR-1:0]    row_pulse,
    output logic [NC-1:0]    col_pulse,
    output logic             row_sense,
    output logic             col_sense,
    output logic             integ,
    output logic             conv_go_row,
    output logic             conv_go_col,
    input  logic             conv_done,
    input  logic [NR*RW-1:0] row_adc,
    input  logic [NC*RW-1:0] col_adc
);
    localparam int NDATA = NMAX - 1;

    logic [W-1:0] vec_q [NDATA];
    xdir_e        dir_q;
    logic         accept, conv_go, latch;
    seq_flags_t   flags;
    logic [NR-1:0] row_last;
    logic [NC-1:0] col_last;
    logic         fwd_load, trn_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NDATA; i++) vec_q[i] <= '0;
        end else if (wr_en && int'(wr_idx) < NDATA) begin
            vec_q[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dir_q <= DIR_FWD;
        else if (accept) dir_q <= xdir_e'(dir_sel);
    end

    assign fwd_load = accept && (xdir_e'(dir_sel) == DIR_FWD);
    assign trn_load = accept && (xdir_e'(dir_sel) == DIR_TRN);

    for (genvar r = 0; r < NR; r++) begin : g_row
        logic [W-1:0] len;
        if (r == NR - 1) begin : g_bias
            assign len = bin_mode ? unit_len : '1;
        end else begin : g_data
            assign len = bin_mode ? (vec_q[r][0] ? unit_len : '0) : vec_q[r];
        end
        xbar_lane #(.W(W)) i_lane (
            .clk(clk), .rst(rst), .load(fwd_load), .len(len),
            .active(row_pulse[r]), .last(row_last[r]));
    end

    for (genvar c = 0; c < NC; c++) begin : g_col
        logic [W-1:0] len;
        if (c == NC - 1) begin : g_bias
            assign len = bin_mode ? unit_len : '1;
        end else begin : g_data
            assign len = bin_mode ? (vec_q[c][0] ? unit_len : '0) : vec_q[c];
        end
        xbar_lane #(.W(W)) i_lane (
            .clk(clk), .rst(rst), .load(trn_load), .len(len),
            .active(col_pulse[c]), .last(col_last[c]));
    end

    xbar_ctrl #(.TAIL(TAIL)) i_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .all_last((&row_last) && (&col_last)),
        .conv_done(conv_done), .accept(accept), .integ(integ),
        .conv_go(conv_go), .latch(latch), .flags(flags));

    xbar_results #(.NR(NR), .NC(NC), .RW(RW), .NMAX(NMAX), .IW(IW)) i_res (
        .clk(clk), .rst(rst), .latch(latch), .dir(dir_q),
        .row_adc(row_adc), .col_adc(col_adc),
        .rd_idx(rd_idx), .rd_data(rd_data));

    assign row_sense   = (dir_q == DIR_TRN);
    assign col_sense   = (dir_q == DIR_FWD);
    assign conv_go_row = conv_go && (dir_q == DIR_TRN);
    assign conv_go_col = conv_go && (dir_q == DIR_FWD);
    assign busy        = flags.busy;
    assign done        = flags.done;
    assign overrun     = flags.overrun;

    assert_no_row_drive_in_sense_R5: assert property (@(posedge clk) disable iff (rst)
        row_sense |-> (row_pulse == '0));
    assert_no_col_drive_in_sense_R5: assert property (@(posedge clk) disable iff (rst)
        col_sense |-> (col_pulse == '0));
    assert_pulse_inside_window_R6: assert property (@(posedge clk) disable iff (rst)
        (|{row_pulse, col_pulse}) |-> integ);
    assert_dir_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dir_q));
endmodule

// File: tb/test_xbar_pwm_seq.sv
module test_xbar_pwm_seq;
    localparam int NR = 6, NC = 4, W = 4, RW = 16, TAIL = 2;
    localparam int NMAX = (NR > NC) ? NR : NC;
    localparam int IW = $clog2(NMAX);
    localparam int FULL = (1 << W) - 1;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 0, start = 0, dir_sel = 0, bin_mode = 0, conv_done = 0;
    logic [IW-1:0] wr_idx = '0, rd_idx = '0;
    logic [W-1:0]  wr_data = '0, unit_len = '0;
    logic busy, done, overrun, row_sense, col_sense, integ, conv_go_row, conv_go_col;
    logic [RW-1:0] rd_data;
    logic [NR-1:0] row_pulse;
    logic [NC-1:0] col_pulse;
    logic [NR*RW-1:0] row_adc;
    logic [NC*RW-1:0] col_adc;

    always #2 clk = ~clk;

    xbar_pwm_seq #(.NR(NR), .NC(NC), .W(W), .RW(RW), .TAIL(TAIL)) i_xbar_pwm_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .start(start), .dir_sel(dir_sel), .bin_mode(bin_mode), .unit_len(unit_len),
        .busy(busy), .done(done), .overrun(overrun), .rd_idx(rd_idx), .rd_data(rd_data),
        .row_pulse(row_pulse), .col_pulse(col_pulse), .row_sense(row_sense),
        .col_sense(col_sense), .integ(integ), .conv_go_row(conv_go_row),
        .conv_go_col(conv_go_col), .conv_done(conv_done), .row_adc(row_adc),
        .col_adc(col_adc));

    int checks = 0, fails = 0, cycles = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int gval(input int r, input int c);
        return ((r * 3 + c * 5) % 7) + 1;
    endfunction

    // ---------------- converter stub: charge = sum of pulse clocks * conductance
    int row_acc [NR];
    int col_acc [NC];
    logic integ_prev = 0;
    int dly = 0;
    always_comb begin
        for (int r = 0; r < NR; r++) row_adc[r*RW +: RW] = RW'(row_acc[r]);
        for (int c = 0; c < NC; c++) col_adc[c*RW +: RW] = RW'(col_acc[c]);
    end
    initial begin
        for (int r = 0; r < NR; r++) row_acc[r] = 0;
        for (int c = 0; c < NC; c++) col_acc[c] = 0;
    end
    always @(negedge clk) begin
        if (!rst) begin
            if (integ && !integ_prev) begin
                for (int r = 0; r < NR; r++) row_acc[r] = 0;
                for (int c = 0; c < NC; c++) col_acc[c] = 0;
            end
            if (integ)
                for (int r = 0; r < NR; r++)
                    for (int c = 0; c < NC; c++) begin
                        if (row_pulse[r]) col_acc[c] += gval(r, c);
                        if (col_pulse[c]) row_acc[r] += gval(r, c);
                    end
            integ_prev = integ;
            conv_done = 1'b0;
            if (conv_go_row || conv_go_col) dly = 3;
            else if (dly > 0) begin
                dly--;
                if (dly == 0) conv_done = 1'b1;
            end
        end
    end

    // ---------------- behavioural reference model
    int m_phase = 0, m_k = 0, m_max = 0;
    int m_dir = 0, m_bin = 0, m_done = 0, m_over = 0;
    int m_vec [NMAX-1];
    int m_w [NMAX];
    int m_res [NMAX];
    initial begin
        for (int i = 0; i < NMAX - 1; i++) m_vec[i] = 0;
        for (int i = 0; i < NMAX; i++) begin m_w[i] = 0; m_res[i] = 0; end
    end

    always @(posedge clk) begin
        int old;
        int ns;
        if (rst) begin
            m_phase = 0; m_k = 0; m_dir = 0; m_bin = 0; m_done = 0; m_over = 0;
            for (int i = 0; i < NMAX - 1; i++) m_vec[i] = 0;
            for (int i = 0; i < NMAX; i++) m_res[i] = 0;
        end else begin
            old = m_phase;
            case (m_phase)
                0: if (start) begin
                    m_dir = dir_sel; m_bin = bin_mode; m_done = 0; m_k = 0; m_max = 0;
                    ns = m_dir ? NC : NR;
                    for (int i = 0; i < NMAX; i++) begin
                        if (i >= ns) m_w[i] = 0;
                        else if (i == ns - 1) m_w[i] = m_bin ? int'(unit_len) : FULL;
                        else if (m_bin) m_w[i] = (m_vec[i] % 2 == 1) ? int'(unit_len) : 0;
                        else m_w[i] = m_vec[i];
                        if (m_w[i] > m_max) m_max = m_w[i];
                    end
                    m_phase = 1;
                end
                1: begin
                    m_k++;
                    if (m_k >= ((m_max < 1) ? 1 : m_max)) begin m_phase = 2; m_k = 0; end
                end
                2: begin m_k++; if (m_k == TAIL) m_phase = 3; end
                3: m_phase = 4;
                default: if (conv_done) begin
                    for (int j = 0; j < NMAX; j++) begin
                        m_res[j] = 0;
                        if (m_dir == 0 && j < NC)
                            for (int r = 0; r < NR; r++) m_res[j] += m_w[r] * gval(r, j);
                        if (m_dir == 1 && j < NR)
                            for (int c = 0; c < NC; c++) m_res[j] += m_w[c] * gval(j, c);
                    end
                    m_done = 1; m_phase = 0;
                end
            endcase
            if (start && old != 0) m_over = 1;
            if (wr_en && int'(wr_idx) < NMAX - 1) m_vec[wr_idx] = int'(wr_data);
        end
    end

    // ---------------- per-cycle comparison
    always @(negedge clk) begin
        int er, ec;
        string tg;
        if (!rst) begin
            cycles++;
            er = 0; ec = 0;
            for (int r = 0; r < NR; r++)
                if (m_phase == 1 && m_dir == 0 && m_k < m_w[r]) er |= (1 << r);
            for (int c = 0; c < NC; c++)
                if (m_phase == 1 && m_dir == 1 && m_k < m_w[c]) ec |= (1 << c);
            tg = m_bin ? "R3" : "R2";
            if (m_dir == 0) begin
                chk({tg, " row data pulses"}, int'(row_pulse[NR-2:0]), er & ((1 << (NR-1)) - 1));
                chk("R4 row bias pulse", int'(row_pulse[NR-1]), (er >> (NR-1)) & 1);
                chk("R5 sensed columns idle", int'(col_pulse), 0);
            end else begin
                chk({tg, " col data pulses"}, int'(col_pulse[NC-2:0]), ec & ((1 << (NC-1)) - 1));
                chk("R4 col bias pulse", int'(col_pulse[NC-1]), (ec >> (NC-1)) & 1);
                chk("R5 sensed rows idle", int'(row_pulse), 0);
            end
            // R10: sense follows the direction latched at start, not dir_sel
            chk("R5 R10 row_sense", int'(row_sense), m_dir);
            chk("R5 R10 col_sense", int'(col_sense), 1 - m_dir);
            chk("R6 integ window", int'(integ), (m_phase == 1 || m_phase == 2) ? 1 : 0);
            chk("R7 conv_go_row", int'(conv_go_row), (m_phase == 3 && m_dir == 1) ? 1 : 0);
            chk("R7 conv_go_col", int'(conv_go_col), (m_phase == 3 && m_dir == 0) ? 1 : 0);
            chk("R8 busy", int'(busy), (m_phase != 0) ? 1 : 0);
            chk("R8 done", int'(done), m_done);
            chk("R9 overrun", int'(overrun), m_over);
        end
    end

    // ---------------- stimulus
    task automatic wr(input int idx, input int val);
        @(negedge clk);
        wr_en = 1; wr_idx = IW'(idx); wr_data = W'(val);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic kick(input int d, input int b, input int u);
        @(negedge clk);
        start = 1; dir_sel = d[0]; bin_mode = b[0]; unit_len = W'(u);
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        for (int n = 0; n < 200 && !(done && !busy); n++) @(negedge clk);
    endtask

    task automatic read_results();
        for (int j = 0; j < NMAX; j++) begin
            @(negedge clk);
            rd_idx = IW'(j);
            #1;
            chk($sformatf("R8 R11 result %0d", j), int'(rd_data), m_res[j]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 pulses", int'({row_pulse, col_pulse}), 0);
        chk("R1 forward sense", int'({row_sense, col_sense}), 1);
        read_results();

        // forward, value coding; one element at full scale
        wr(0, 3); wr(1, 0); wr(2, 7); wr(3, 1); wr(4, 15);
        kick(0, 0, 0); wait_done(); read_results();

        // forward, binary coding: 2 has bit 0 clear so it must not pulse
        wr(0, 1); wr(1, 2); wr(2, 1); wr(3, 0); wr(4, 1);
        kick(0, 1, 4); wait_done(); read_results();

        // transpose, value coding
        wr(0, 2); wr(1, 9); wr(2, 0);
        kick(1, 0, 0); wait_done(); read_results();

        // transpose, binary coding, unit length 1
        wr(0, 1); wr(1, 1); wr(2, 0);
        kick(1, 1, 1); wait_done(); read_results();

        // R9 R10: restart and input changes while busy are ignored
        wr(0, 5); wr(1, 1); wr(2, 6); wr(3, 0); wr(4, 2);
        kick(0, 0, 0);
        repeat (2) @(negedge clk);
        start = 1; dir_sel = 1; bin_mode = 1; unit_len = 3;
        @(negedge clk);
        start = 0;
        wait_done(); read_results();
        chk("R9 overrun held", int'(overrun), 1);

        // R6: binary with zero unit length, no line pulses at all
        kick(0, 1, 0); wait_done(); read_results();

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule